// File: doc/BRIEF.md
# Calibrated 12/24-Hour Timekeeping Core

This core keeps time of day from a single reference clock that is nominally 262144 Hz. Each clock cycle of that reference is one pulse. The crystal behind it is trimmed to run slightly fast, so every one-second frame begins by discarding a programmable number of pulses. The frame then counts a full second's worth of pulses. From the resulting once-per-second tick, the core advances seconds, minutes and hours. It presents hours and minutes as two-digit BCD values for a four-digit display, together with an AM/PM flag and a colon-enable bit.

A button controller outside the core turns switch presses into single-cycle strobes. An hour strobe advances the hours alone. A minute strobe advances the minutes and restarts the current minute by zeroing the seconds.

A mode pin chooses 12-hour or 24-hour presentation, and the core starts in a different state for each mode. A colon-flash select chooses between a blinking colon and a steady colon. A test-stop input freezes the time-of-day counters so that the display can be stepped through its values with the strobes alone.

Top module: `tk_clock_core`

## Requirements
- R1: While reset is high and for the first cycles after it, the outputs show 01:00 with pm_o=0 when mode_12h=1, and 00:00 with pm_o=0 when mode_12h=0.
- R2: With mode_12h=1, hours_bcd takes the values 0x12, 0x01 … 0x11. pm_o inverts whenever the display passes from 11 to 12, whether by counting or by the hour strobe.
- R3: With mode_12h=0, hours_bcd takes the values 0x00 … 0x23 and pm_o stays 0.
- R4: Each inc_hour cycle adds one hour and wraps within the mode's range. Minutes are left unchanged.
- R5: Each inc_min cycle adds one minute, wrapping 59→00 without any carry into the hours, and sets the seconds to zero.
- R6: While test_stop=1, the displayed time does not change from the timebase, but inc_hour and inc_min still act.
- R7: Each one-second frame lasts cal_drop+REF_HZ reference cycles, with cal_drop sampled at the start of the frame. At 60 seconds per minute, a minute therefore lasts 60*(cal_drop+REF_HZ) cycles.
- R8: Counting from the timebase carries 59 seconds into the minutes and 59 minutes into the hours. 23:59 becomes 00:00 in 24-hour mode, and 11:59 AM becomes 12:00 PM in 12-hour mode.
- R9: With flash_en=1, colon_o inverts once per one-second frame. With flash_en=0, colon_o is held at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, one pulse per cycle |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| mode_12h | input | 1 | 1 selects 12-hour, 0 selects 24-hour presentation |
| flash_en | input | 1 | 1 blinks the colon, 0 holds it on |
| test_stop | input | 1 | 1 freezes counting from the timebase |
| inc_hour | input | 1 | Single-cycle hour advance strobe |
| inc_min | input | 1 | Single-cycle minute advance strobe (also zeroes seconds) |
| cal_drop | input | CAL_W | Reference pulses discarded at the start of each frame |
| hours_bcd | output | 8 | Hours, two BCD digits (tens in [7:4]) |
| mins_bcd | output | 8 | Minutes, two BCD digits (tens in [7:4]) |
| pm_o | output | 1 | PM flag in 12-hour mode, 0 in 24-hour mode |
| colon_o | output | 1 | Colon segment enable |

## Verification
The internal state is a hidden frame counter and a hidden seconds count, so errors in them appear at the ports only through timing. A prescaler fault shows up as a minute period that differs from 60*(cal_drop+REF_HZ) cycles, visible within one displayed minute. A seconds count that is not cleared shows as a minute arriving too early after a minute strobe. Hour and minute state faults show directly on the BCD outputs two cycles after a strobe, which the vector walk exercises across both wrap points and both modes.

// File: rtl/tk_pkg.sv
package tk_pkg;
  localparam int unsigned SEC_LAST  = 59;
  localparam int unsigned MIN_LAST  = 59;
  localparam int unsigned HOUR_LAST = 23;
  localparam int unsigned HALF_DAY  = 12;

  typedef logic [7:0] bcd2_t;

  // Binary 0..99 to two packed BCD digits.
  function automatic bcd2_t to_bcd2(input logic [6:0] v);
    logic [6:0] tens;
    logic [6:0] units;
    tens  = v / 7'd10;
    units = v - tens * 7'd10;
    return {tens[3:0], units[3:0]};
  endfunction
endpackage

// File: rtl/tk_prescaler.sv
module tk_prescaler #(
  parameter int unsigned REF_HZ = 262144,
  parameter int unsigned CAL_W  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CAL_W-1:0] cal_drop,
  output logic             sec_tick
);
  localparam int unsigned FRAME_MAX = REF_HZ + (1 << CAL_W);
  localparam int unsigned FW        = $clog2(FRAME_MAX);

  logic [FW-1:0]    frame_cnt;
  logic [FW-1:0]    last_w;
  logic [CAL_W-1:0] cal_q;

  // Frame = cal_q swallowed pulses followed by REF_HZ counted pulses.
  assign last_w = FW'(cal_q) + FW'(REF_HZ - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_cnt <= '0;
      cal_q     <= cal_drop;
      sec_tick  <= 1'b0;
    end else begin
      sec_tick <= (frame_cnt == last_w);
      if (frame_cnt == last_w) begin
        frame_cnt <= '0;
        cal_q     <= cal_drop;
      end else begin
        frame_cnt <= frame_cnt + 1'b1;
      end
    end
  end

  // R7: the frame counter never passes the end of the latched frame
  p_frame_bound_r7: assert property (@(posedge clk) disable iff (rst)
    frame_cnt <= last_w);

  // R7: ticks are isolated single-cycle pulses
  p_tick_single_r7: assert property (@(posedge clk) disable iff (rst)
    sec_tick |=> !sec_tick);
endmodule

// File: rtl/tk_timecount.sv
module tk_timecount (
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_12h,
  input  logic       test_stop,
  input  logic       inc_hour,
  input  logic       inc_min,
  input  logic       sec_tick,
  output logic [5:0] min_q,
  output logic [4:0] hr_q
);
  import tk_pkg::*;

  logic [5:0] sec_q;
  logic [5:0] min_nx;
  logic [4:0] hr_nx;
  logic       set_any;

  // Hours are held in 24-hour form; 12-hour view is derived downstream.
  assign min_nx  = (min_q == 6'(MIN_LAST))  ? 6'd0 : min_q + 6'd1;
  assign hr_nx   = (hr_q  == 5'(HOUR_LAST)) ? 5'd0 : hr_q  + 5'd1;
  assign set_any = inc_hour | inc_min;

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q <= '0;
      min_q <= '0;
      hr_q  <= mode_12h ? 5'd1 : 5'd0;
    end else if (set_any) begin
      // Strobes win over a coincident tick; they never carry.
      if (inc_min) begin
        min_q <= min_nx;
        sec_q <= '0;
      end
      if (inc_hour) begin
        hr_q <= hr_nx;
      end
    end else if (sec_tick && !test_stop) begin
      if (sec_q == 6'(SEC_LAST)) begin
        sec_q <= '0;
        min_q <= min_nx;
        if (min_q == 6'(MIN_LAST)) begin
          hr_q <= hr_nx;
        end
      end else begin
        sec_q <= sec_q + 6'd1;
      end
    end
  end

  // R5: minute strobe leaves the seconds at zero
  p_sec_clear_r5: assert property (@(posedge clk) disable iff (rst)
    inc_min |=> (sec_q == 6'd0));

  // R4: hour strobe alone does not disturb minutes
  p_min_kept_r4: assert property (@(posedge clk) disable iff (rst)
    (inc_hour && !inc_min) |=> $stable(min_q));

  // R6: frozen counters without strobes
  p_hold_stop_r6: assert property (@(posedge clk) disable iff (rst)
    (test_stop && !set_any) |=> ($stable(sec_q) && $stable(min_q) && $stable(hr_q)));

  // R8: counters stay within range
  p_range_r8: assert property (@(posedge clk) disable iff (rst)
    (sec_q <= 6'(SEC_LAST)) && (min_q <= 6'(MIN_LAST)) && (hr_q <= 5'(HOUR_LAST)));
endmodule

// File: rtl/tk_display_fmt.sv
module tk_display_fmt (
  input  logic       clk,
  input  logic       rst,
  input  logic       mode_12h,
  input  logic       flash_en,
  input  logic       sec_tick,
  input  logic [5:0] min_q,
  input  logic [4:0] hr_q,
  output logic [7:0] hours_bcd,
  output logic [7:0] mins_bcd,
  output logic       pm_o,
  output logic       colon_o
);
  import tk_pkg::*;

  logic       phase_q;
  logic       after_noon;
  logic [4:0] hr_mod;
  logic [4:0] hr_show;

  assign after_noon = (hr_q >= 5'(HALF_DAY));
  assign hr_mod     = after_noon ? hr_q - 5'(HALF_DAY) : hr_q;

  always_comb begin
    if (mode_12h) begin
      hr_show = (hr_mod == 5'd0) ? 5'(HALF_DAY) : hr_mod;
    end else begin
      hr_show = hr_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= 1'b1;
      hours_bcd <= mode_12h ? 8'h01 : 8'h00;
      mins_bcd  <= 8'h00;
      pm_o      <= 1'b0;
      colon_o   <= 1'b1;
    end else begin
      if (sec_tick) begin
        phase_q <= ~phase_q;
      end
      hours_bcd <= to_bcd2({2'b00, hr_show});
      mins_bcd  <= to_bcd2({1'b0, min_q});
      pm_o      <= mode_12h & after_noon;
      colon_o   <= flash_en ? phase_q : 1'b1;
    end
  end

  // R9: steady colon when flashing is off
  p_colon_steady_r9: assert property (@(posedge clk) disable iff (rst)
    !flash_en |=> colon_o);

  // R3: no PM indication in 24-hour mode
  p_pm_24h_r3: assert property (@(posedge clk) disable iff (rst)
    !mode_12h |=> !pm_o);

  // R2: 12-hour display never shows hour zero
  p_no_zero_hour_r2: assert property (@(posedge clk) disable iff (rst)
    mode_12h |=> (hours_bcd != 8'h00));

  // R8: BCD digits are legal
  p_bcd_digits_r8: assert property (@(posedge clk) disable iff (rst)
    (hours_bcd[3:0] <= 4'd9) && (mins_bcd[3:0] <= 4'd9) && (mins_bcd[7:4] <= 4'd5));
endmodule

// File: rtl/tk_clock_core.sv
module tk_clock_core #(
  parameter int unsigned REF_HZ = 262144,
  parameter int unsigned CAL_W  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_12h,
  input  logic             flash_en,
  input  logic             test_stop,
  input  logic             inc_hour,
  input  logic             inc_min,
  input  logic [CAL_W-1:0] cal_drop,
  output logic [7:0]       hours_bcd,
  output logic [7:0]       mins_bcd,
  output logic             pm_o,
  output logic             colon_o
);
  logic       sec_tick;
  logic [5:0] min_q;
  logic [4:0] hr_q;

  tk_prescaler #(.REF_HZ(REF_HZ), .CAL_W(CAL_W)) u_pre (
    .clk      (clk),
    .rst      (rst),
    .cal_drop (cal_drop),
    .sec_tick (sec_tick)
  );

  tk_timecount u_cnt (
    .clk       (clk),
    .rst       (rst),
    .mode_12h  (mode_12h),
    .test_stop (test_stop),
    .inc_hour  (inc_hour),
    .inc_min   (inc_min),
    .sec_tick  (sec_tick),
    .min_q     (min_q),
    .hr_q      (hr_q)
  );

  tk_display_fmt u_fmt (
    .clk       (clk),
    .rst       (rst),
    .mode_12h  (mode_12h),
    .flash_en  (flash_en),
    .sec_tick  (sec_tick),
    .min_q     (min_q),
    .hr_q      (hr_q),
    .hours_bcd (hours_bcd),
    .mins_bcd  (mins_bcd),
    .pm_o      (pm_o),
    .colon_o   (colon_o)
  );
endmodule

// File: tb/tb_tk_clock_core.sv
module tb_tk_clock_core;
  localparam int unsigned REF_HZ = 8;
  localparam int unsigned CAL_W  = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_12h = 1'b1, flash_en = 1'b0, test_stop = 1'b1;
  logic inc_hour = 1'b0, inc_min = 1'b0;
  logic [CAL_W-1:0] cal_drop = '0;
  logic [7:0] hours_bcd, mins_bcd;
  logic pm_o, colon_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  tk_clock_core #(.REF_HZ(REF_HZ), .CAL_W(CAL_W)) dut (
    .clk(clk), .rst(rst), .mode_12h(mode_12h), .flash_en(flash_en),
    .test_stop(test_stop), .inc_hour(inc_hour), .inc_min(inc_min),
    .cal_drop(cal_drop), .hours_bcd(hours_bcd), .mins_bcd(mins_bcd),
    .pm_o(pm_o), .colon_o(colon_o)
  );

  // Rows: {mode, hour strobes, minute strobes, exp hours, exp mins, exp pm}
  localparam logic [47:0] VEC [11] = '{
    {8'd1, 8'd10, 8'd0,  8'h11, 8'h00, 8'd0},  // R2 up to 11 AM
    {8'd1, 8'd1,  8'd0,  8'h12, 8'h00, 8'd1},  // R2 11->12 sets PM
    {8'd1, 8'd1,  8'd0,  8'h01, 8'h00, 8'd1},  // R2 12->1
    {8'd1, 8'd0,  8'd59, 8'h01, 8'h59, 8'd1},  // R5 minutes only
    {8'd1, 8'd0,  8'd1,  8'h01, 8'h00, 8'd1},  // R5 wrap, no carry
    {8'd1, 8'd11, 8'd0,  8'h12, 8'h00, 8'd0},  // R4 11 PM -> 12 AM
    {8'd0, 8'd0,  8'd0,  8'h00, 8'h00, 8'd0},  // R3 midnight view
    {8'd0, 8'd23, 8'd0,  8'h23, 8'h00, 8'd0},  // R3 top of range
    {8'd0, 8'd1,  8'd0,  8'h00, 8'h00, 8'd0},  // R4 wrap 23->0
    {8'd0, 8'd12, 8'd7,  8'h12, 8'h07, 8'd0},  // R3 no pm in 24h
    {8'd1, 8'd0,  8'd0,  8'h12, 8'h07, 8'd1}   // R2 same time as 12 PM
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset(input logic m);
    @(negedge clk);
    mode_12h = m;
    rst = 1'b1;
    tick(3);
    rst = 1'b0;
    tick(1);
  endtask

  task automatic pulse_hour(input int n);
    for (int i = 0; i < n; i++) begin
      inc_hour = 1'b1; tick(1); inc_hour = 1'b0; tick(1);
    end
  endtask

  task automatic pulse_min(input int n);
    for (int i = 0; i < n; i++) begin
      inc_min = 1'b1; tick(1); inc_min = 1'b0; tick(1);
    end
  endtask

  task automatic wait_min_change(input int limit, output int cyc);
    logic [7:0] prev;
    prev = mins_bcd;
    cyc = 0;
    while (mins_bcd == prev && cyc < limit) begin
      tick(1);
      cyc++;
    end
  endtask

  task automatic wait_colon_change(input int limit, output int cyc);
    logic prev;
    prev = colon_o;
    cyc = 0;
    while (colon_o == prev && cyc < limit) begin
      tick(1);
      cyc++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int d;
    logic [7:0] h0, m0;

    // R1 power-on values per mode
    do_reset(1'b0);
    check("R1 24h hours", 32'(hours_bcd), 32'h00);
    check("R1 24h mins", 32'(mins_bcd), 32'h00);
    do_reset(1'b1);
    check("R1 12h hours", 32'(hours_bcd), 32'h01);
    check("R1 12h pm", 32'(pm_o), 32'd0);
    check("R9 colon steady at reset", 32'(colon_o), 32'd1);

    // Vector walk with counting frozen
    for (int r = 0; r < 11; r++) begin
      mode_12h = VEC[r][47:40] != 8'd0;
      pulse_hour(int'(VEC[r][39:32]));
      pulse_min(int'(VEC[r][31:24]));
      tick(2);
      check($sformatf("R4/R5 row %0d hours", r), 32'(hours_bcd), 32'(VEC[r][23:16]));
      check($sformatf("R4/R5 row %0d mins", r), 32'(mins_bcd), 32'(VEC[r][15:8]));
      check($sformatf("R2/R3 row %0d pm", r), 32'(pm_o), 32'(VEC[r][7:0]));
    end

    // R6 frozen while stopped
    h0 = hours_bcd; m0 = mins_bcd;
    tick(900);
    check("R6 hours held", 32'(hours_bcd), 32'(h0));
    check("R6 mins held", 32'(mins_bcd), 32'(m0));

    // R7 minute length for two calibration values
    test_stop = 1'b0;
    wait_min_change(2000, d);
    wait_min_change(2000, d);
    check("R7 minute period cal=0", 32'(d), 32'(60 * REF_HZ));
    cal_drop = 6'd5;
    wait_min_change(2000, d);
    wait_min_change(2000, d);
    check("R7 minute period cal=5", 32'(d), 32'(60 * (REF_HZ + 5)));

    // R9 colon blink period and steady mode
    flash_en = 1'b1;
    wait_colon_change(100, d);
    wait_colon_change(100, d);
    check("R9 colon toggle interval", 32'(d), 32'(REF_HZ + 5));
    flash_en = 1'b0;
    tick(2);
    d = 0;
    for (int i = 0; i < 40; i++) begin
      if (colon_o !== 1'b1) d++;
      tick(1);
    end
    check("R9 colon steady low-select", 32'(d), 32'd0);

    // R5 minute strobe restarts the minute
    wait_min_change(2000, d);
    tick(30 * (REF_HZ + 5));
    pulse_min(1);
    wait_min_change(2000, d);
    checks++;
    if (d <= 59 * (REF_HZ + 5) || d > 61 * (REF_HZ + 5)) begin
      errors++;
      $display("FAIL R5 seconds cleared actual=%0d expected=%0d..%0d",
               d, 59 * (REF_HZ + 5) + 1, 61 * (REF_HZ + 5));
    end

    // R8/R3 24-hour rollover by counting
    cal_drop = 6'd0;
    test_stop = 1'b1;
    do_reset(1'b0);
    pulse_hour(23);
    pulse_min(59);
    tick(2);
    check("R8 preset 23h", 32'(hours_bcd), 32'h23);
    test_stop = 1'b0;
    wait_min_change(2000, d);
    tick(2);
    check("R8 24h rollover hours", 32'(hours_bcd), 32'h00);
    check("R8 24h rollover mins", 32'(mins_bcd), 32'h00);

    // R8/R2 12-hour 11:59 AM -> 12:00 PM by counting
    test_stop = 1'b1;
    do_reset(1'b1);
    pulse_hour(10);
    pulse_min(59);
    test_stop = 1'b0;
    wait_min_change(2000, d);
    tick(2);
    check("R8 12h rollover hours", 32'(hours_bcd), 32'h12);
    check("R2 12h rollover pm", 32'(pm_o), 32'd1);

    // R6 strobes act under test_stop (single step)
    test_stop = 1'b1;
    tick(2);
    pulse_hour(1);
    tick(2);
    check("R6 strobe under stop", 32'(hours_bcd), 32'h01);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule